// File: doc/BRIEF.md
# Mode-Switchable Wormhole Router Pipeline

This block is one router of a two-dimensional mesh. It has five ports: four mesh neighbours and one local core port. Flits are 66 bits wide. Packets have variable length and move in wormhole fashion. Each input has a small FIFO. A shared allocator picks, for each output, which input may use the crossbar. Each output can hold the flit in a latch before it leaves. The output port of a packet is computed one hop ahead and travels in the head flit, so the router only decodes a field. It does not run a routing algorithm.

The local processor sets the per-hop pipeline depth at run time. Depth one gives the lowest latency: a flit crosses allocation and the crossbar in the cycle after it is accepted, straight from the FIFO head. Depth two adds the output latch, which shortens the longest combinational path. Depth three also adds a stage register between each FIFO and the allocator. All three depths share the same buffers and arbiters. Only the bypass muxes change.

A mode write never disturbs traffic. The write is kept pending, and it takes effect on the first cycle in which the router is fully empty and nothing is arriving.

Top module: `vp_router`

## Requirements
- R1: A flit carries its kind in bits [65:64]: 2'b00 head, 2'b01 body, 2'b10 tail, 2'b11 single-flit packet. On a head or single flit, bits [2:0] select the output port: 0 North, 1 East, 2 West, 3 South, 4 Local. Values 5 to 7 go to Local. Body and tail flits follow the port of their head. Flits leave the router bit-for-bit unchanged.
- R2: The mode is written through `mode_wr_data`: 2'd1, 2'd2 or 2'd3 selects that many cycles per hop. A write of 2'd0 is ignored. After reset the mode is 2'd2.
- R3: In mode 1, a flit accepted at a clock edge is offered on its output during the cycle that follows that edge.
- R4: In mode 2, the flit is offered on its output one cycle later than in mode 1, through the output latch.
- R5: In mode 3, the flit is offered on its output two cycles later than in mode 1, through the stage register and then the output latch.
- R6: On a fully idle cycle (no input valid, all buffers and latches empty, no output reserved), a write changes `mode_o` at the next edge. A write made while flits are present is held. It is applied on the first idle cycle, and a later write replaces a held one.
- R7: An output that has started a multi-flit packet passes only that packet's flits until its tail. Flits of other packets never interleave with it.
- R8: When two or more inputs have head flits waiting for the same free output, they are served in round-robin order. Two inputs that keep a backlog for one output alternate.
- R9: `in_ready` drops when the input FIFO (depth 4 by default) is full. No flit is lost or reordered. In modes 2 and 3, a valid output that is stalled by `out_ready` keeps its flit stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr_en | input | 1 | Mode write strobe from the local processor |
| mode_wr_data | input | 2 | Requested cycles per hop (1..3) |
| mode_o | output | 2 | Pipeline depth currently in effect |
| in_valid | input | 5 | Per-input flit valid |
| in_flit | input | 330 | Per-input flit, port p at bits [66p+65:66p] |
| in_ready | output | 5 | Per-input ready (FIFO not full) |
| out_valid | output | 5 | Per-output flit valid |
| out_flit | output | 330 | Per-output flit, port p at bits [66p+65:66p] |
| out_ready | input | 5 | Per-output ready from downstream |

## Verification
The assertions assume well-formed packets on every input: a head, then bodies, then a tail, or a single flit alone. The wormhole check on the outputs is only meaningful for such packets. They also assume that a driver holds its flit while `in_ready` is low. The stimulus only ever sends complete, correctly framed packets. It keeps `in_valid` and the flit unchanged until the acceptance edge, and it drops `in_valid` as soon as the flit is taken. Mode writes are made both with the router idle and with a flit stalled in an output latch, so both the immediate path and the deferred path are exercised.

// File: rtl/vp_pkg.sv
// Shared encodings for the mode-switchable router.
// Assumes: flit kind in the top two bits, look-ahead port field in bits [2:0].
package vp_pkg;
    typedef enum logic [1:0] {
        FK_HEAD   = 2'b00,
        FK_BODY   = 2'b01,
        FK_TAIL   = 2'b10,
        FK_SINGLE = 2'b11
    } flit_kind_e;

    localparam logic [1:0] DEPTH_ONE   = 2'd1;
    localparam logic [1:0] DEPTH_TWO   = 2'd2;
    localparam logic [1:0] DEPTH_THREE = 2'd3;

    localparam int ROUTE_W = 3;
    localparam int LOCAL_PORT = 4;

    // Map a look-ahead field onto a port index; out-of-range codes go local.
    function automatic logic [ROUTE_W-1:0] decode_route(input logic [ROUTE_W-1:0] f);
        return (f > ROUTE_W'(LOCAL_PORT)) ? ROUTE_W'(LOCAL_PORT) : f;
    endfunction

    // True for a flit that opens a packet.
    function automatic logic is_opener(input logic [1:0] k);
        return (k == FK_HEAD) || (k == FK_SINGLE);
    endfunction
endpackage

// File: rtl/vp_in_fifo.sv
// Input FIFO of one router port.
// What it does: stores flits in order and raises ready only while space remains.
// Assumes: the writer holds data stable while wr_valid is high and wr_ready is low.
module vp_in_fifo #(
    parameter int W     = 66,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    output logic         wr_ready,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    input  logic         rd_ready,
    output logic         empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          push, pop;

    // Advance a pointer with wrap at the configured depth.
    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Handshake decode.
    always_comb begin
        wr_ready = (cnt_q != CW'(DEPTH));
        rd_valid = (cnt_q != '0);
        rd_data  = mem[rp_q];
        empty_o  = (cnt_q == '0);
        push     = wr_valid && wr_ready;
        pop      = rd_valid && rd_ready;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= wr_data;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= step(wp_q);
            if (pop)  rp_q <= step(rp_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/vp_pipe_slot.sv
// One optional pipeline register with a valid/ready handshake.
// What it does: with en high it holds one flit and allows a push and a pop in the same cycle;
// with en low it is a plain wire.
// Assumes: en only changes while the slot is empty (the router only switches mode when idle).
module vp_pipe_slot #(
    parameter int W = 66
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         up_valid,
    input  logic [W-1:0] up_data,
    output logic         up_ready,
    output logic         dn_valid,
    output logic [W-1:0] dn_data,
    input  logic         dn_ready,
    output logic         occupied
);
    logic         vld_q;
    logic [W-1:0] dat_q;

    // Select between the register and the bypass.
    always_comb begin
        if (en) begin
            dn_valid = vld_q;
            dn_data  = dat_q;
            up_ready = !vld_q || dn_ready;
        end else begin
            dn_valid = up_valid;
            dn_data  = up_data;
            up_ready = dn_ready;
        end
        occupied = vld_q;
    end

    // Valid flag of the held flit.
    always_ff @(posedge clk) begin
        if (!rst_n)                vld_q <= 1'b0;
        else if (en && up_ready)   vld_q <= up_valid;
    end

    // Payload capture.
    always_ff @(posedge clk) begin
        if (en && up_ready && up_valid) dat_q <= up_data;
    end
endmodule

// File: rtl/vp_out_arb.sv
// Arbiter of one output port.
// What it does: picks one requesting input by round robin, and keeps that input
// reserved from a head flit through its tail.
// Assumes: req holds one bit per input whose current flit targets this output;
// fire reports the flit that crossed, and kind is its type.
module vp_out_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         fire,
    input  logic [1:0]   kind,
    output logic [N-1:0] gnt,
    output logic         locked
);
    import vp_pkg::*;
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q;
    logic [N-1:0]  owner_q;
    logic          lock_q;
    logic [PW-1:0] win;
    logic          found;

    // Rotating-priority search, overridden by an active reservation.
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                found = 1'b1;
                win   = PW'(j);
            end
        end
        gnt = '0;
        if (lock_q)     gnt = owner_q & req;
        else if (found) gnt[win] = 1'b1;
        locked = lock_q;
    end

    // Reservation and priority pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            owner_q <= '0;
            lock_q  <= 1'b0;
        end else if (fire) begin
            if (!lock_q) begin
                ptr_q <= (win == PW'(N - 1)) ? '0 : win + 1'b1;
                if (kind == FK_HEAD) begin
                    lock_q  <= 1'b1;
                    owner_q <= gnt;
                end
            end else if (kind == FK_TAIL) begin
                lock_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vp_mode_ctl.sv
// Pipeline-depth register with deferred application.
// What it does: keeps the latest legal write pending and applies it on an idle cycle.
// Assumes: idle is high only when no flit is stored, reserved or arriving.
module vp_mode_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    input  logic       idle,
    output logic [1:0] mode
);
    import vp_pkg::*;
    logic [1:0] mode_q, pend_q;
    logic       pend_v_q, wr_ok, want_v;
    logic [1:0] want;

    // Newest request wins over an older pending one.
    always_comb begin
        wr_ok  = wr_en && (wr_data != 2'd0);
        want   = wr_ok ? wr_data : pend_q;
        want_v = wr_ok || pend_v_q;
        mode   = mode_q;
    end

    // Apply when idle, otherwise remember.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= DEPTH_TWO;
            pend_q   <= DEPTH_TWO;
            pend_v_q <= 1'b0;
        end else if (want_v && idle) begin
            mode_q   <= want;
            pend_v_q <= 1'b0;
        end else if (wr_ok) begin
            pend_q   <= wr_data;
            pend_v_q <= 1'b1;
        end
    end
endmodule

// File: rtl/vp_router.sv
// Five-port wormhole router with run-time pipeline depth of one, two or three cycles.
// What it does: buffers each input, decodes the look-ahead port field, allocates each output
// with a reserved round-robin arbiter, drives the crossbar, and optionally latches each output.
// Assumes: inputs carry well-formed packets; the head flit holds the precomputed output port.
module vp_router #(
    parameter int NPORT      = 5,
    parameter int DATA_W     = 64,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_wr_en,
    input  logic [1:0]                mode_wr_data,
    output logic [1:0]                mode_o,
    input  logic [NPORT-1:0]          in_valid,
    input  logic [NPORT*(DATA_W+2)-1:0] in_flit,
    output logic [NPORT-1:0]          in_ready,
    output logic [NPORT-1:0]          out_valid,
    output logic [NPORT*(DATA_W+2)-1:0] out_flit,
    input  logic [NPORT-1:0]          out_ready
);
    import vp_pkg::*;
    localparam int FW = DATA_W + 2;

    logic [FW-1:0]      fifo_data [NPORT];
    logic [FW-1:0]      stg_data  [NPORT];
    logic [FW-1:0]      snk_data  [NPORT];
    logic [NPORT-1:0]   fifo_valid, fifo_pop, fifo_empty;
    logic [NPORT-1:0]   stg_valid, stg_occ, lat_occ;
    logic [NPORT-1:0]   snk_valid, snk_ready, locked, in_fire;
    logic [ROUTE_W-1:0] want_port [NPORT];
    logic [NPORT-1:0]   req_mat [NPORT];
    logic [NPORT-1:0]   gnt_mat [NPORT];
    logic [NPORT*NPORT-1:0] gnt_flat;
    logic               idle;
    logic [1:0]         mode;

    vp_mode_ctl u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(mode_wr_en), .wr_data(mode_wr_data),
        .idle(idle), .mode(mode)
    );
    assign mode_o = mode;

    // Router is idle when nothing is stored, reserved or arriving.
    always_comb begin
        idle = (&fifo_empty) && !(|stg_occ) && !(|lat_occ) && !(|in_valid) && !(|locked);
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        logic [ROUTE_W-1:0] cur_route_q;
        logic [1:0]         kind;

        vp_in_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .wr_valid(in_valid[i]), .wr_data(in_flit[i*FW +: FW]), .wr_ready(in_ready[i]),
            .rd_valid(fifo_valid[i]), .rd_data(fifo_data[i]), .rd_ready(fifo_pop[i]),
            .empty_o(fifo_empty[i])
        );

        vp_pipe_slot #(.W(FW)) u_stage (
            .clk(clk), .rst_n(rst_n), .en(mode == DEPTH_THREE),
            .up_valid(fifo_valid[i]), .up_data(fifo_data[i]), .up_ready(fifo_pop[i]),
            .dn_valid(stg_valid[i]), .dn_data(stg_data[i]), .dn_ready(in_fire[i]),
            .occupied(stg_occ[i])
        );

        // Port wanted by the flit at the head of this input.
        always_comb begin
            kind = stg_data[i][FW-1 -: 2];
            want_port[i] = is_opener(kind) ? decode_route(stg_data[i][ROUTE_W-1:0]) : cur_route_q;
        end

        // Remember the head's port for the rest of the packet.
        always_ff @(posedge clk) begin
            if (!rst_n)                              cur_route_q <= '0;
            else if (in_fire[i] && kind == FK_HEAD)  cur_route_q <= want_port[i];
        end
    end

    // Request matrix and per-input transfer strobes.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_mat[o][i] = stg_valid[i] && (want_port[i] == ROUTE_W'(o));
            end
        end
        in_fire = '0;
        for (int i = 0; i < NPORT; i++) begin
            for (int o = 0; o < NPORT; o++) begin
                if (gnt_mat[o][i] && snk_ready[o]) in_fire[i] = 1'b1;
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        logic [FW-1:0] mux;

        vp_out_arb #(.N(NPORT)) u_arb (
            .clk(clk), .rst_n(rst_n), .req(req_mat[o]),
            .fire(snk_valid[o] && snk_ready[o]), .kind(snk_data[o][FW-1 -: 2]),
            .gnt(gnt_mat[o]), .locked(locked[o])
        );

        // Crossbar column: AND-OR select of the granted input.
        always_comb begin
            mux = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (gnt_mat[o][i]) mux = mux | stg_data[i];
            end
            snk_valid[o] = |gnt_mat[o];
            snk_data[o]  = mux;
            gnt_flat[o*NPORT +: NPORT] = gnt_mat[o];
        end

        vp_pipe_slot #(.W(FW)) u_latch (
            .clk(clk), .rst_n(rst_n), .en(mode != DEPTH_ONE),
            .up_valid(snk_valid[o]), .up_data(snk_data[o]), .up_ready(snk_ready[o]),
            .dn_valid(out_valid[o]), .dn_data(out_flit[o*FW +: FW]), .dn_ready(out_ready[o]),
            .occupied(lat_occ[o])
        );
    end
endmodule

// File: rtl/vp_router_chk.sv
// Property checker for vp_router, attached by bind.
// Assumes: well-formed packets on every input.
module vp_router_chk #(
    parameter int N  = 5,
    parameter int FW = 66
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     mode_o,
    input logic [N-1:0]   in_valid,
    input logic [N-1:0]   out_valid,
    input logic [N-1:0]   out_ready,
    input logic [N*FW-1:0] out_flit,
    input logic [N*N-1:0] gnt_flat
);
    // R2: the depth in effect is always a legal code.
    a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n) mode_o != 2'd0);

    // R6: the depth only changes after a cycle with no traffic at the edges.
    a_r6_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != $past(mode_o)) |-> ($past(in_valid) == '0 && $past(out_valid) == '0));

    for (genvar o = 0; o < N; o++) begin : g_p
        logic open_q;
        logic [1:0] k;
        assign k = out_flit[o*FW + FW - 2 +: 2];

        // Track whether a multi-flit packet is in progress on this output.
        always_ff @(posedge clk) begin
            if (!rst_n) open_q <= 1'b0;
            else if (out_valid[o] && out_ready[o]) begin
                if (k == 2'b00)      open_q <= 1'b1;
                else if (k == 2'b10) open_q <= 1'b0;
            end
        end

        // R7: no new packet starts inside an open one, and no continuation appears outside one.
        a_r7_wormhole: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && out_ready[o]) |->
                (open_q ? (k == 2'b01 || k == 2'b10) : (k == 2'b00 || k == 2'b11)));

        // R9: a stalled latched output keeps its flit.
        a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_o != 2'd1 && out_valid[o] && !out_ready[o]) |=>
                (out_valid[o] && $stable(out_flit[o*FW +: FW])));

        // R8: at most one input granted per output.
        a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_flat[o*N +: N]));
    end
endmodule

bind vp_router vp_router_chk #(.N(NPORT), .FW(DATA_W + 2)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .in_valid(in_valid),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit), .gnt_flat(gnt_flat)
);

// File: tb/sim_vp_router.sv
module sim_vp_router;
    localparam int N = 5;
    localparam int FW = 66;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr_en = 1'b0;
    logic [1:0] mode_wr_data = 2'd0;
    logic [1:0] mode_o;
    logic [N-1:0] in_valid = '0;
    logic [N*FW-1:0] in_flit = '0;
    logic [N-1:0] in_ready, out_valid;
    logic [N*FW-1:0] out_flit;
    logic [N-1:0] out_ready = '1;

    int tests = 0;
    int fails = 0;
    logic [FW-1:0] lg [N][64];
    int lc [N];

    always #5 clk = ~clk;

    vp_router u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .mode_o(mode_o), .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
        .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [2:0] src;
        logic [2:0] rfield;
        logic [2:0] dport;
        logic [2:0] lat;
    } vec_t;

    localparam vec_t VT [9] = '{
        '{2'd1, 3'd0, 3'd1, 3'd1, 3'd1},
        '{2'd1, 3'd4, 3'd3, 3'd3, 3'd1},
        '{2'd1, 3'd2, 3'd7, 3'd4, 3'd1},
        '{2'd2, 3'd1, 3'd0, 3'd0, 3'd2},
        '{2'd2, 3'd3, 3'd4, 3'd4, 3'd2},
        '{2'd2, 3'd0, 3'd2, 3'd2, 3'd2},
        '{2'd3, 3'd4, 3'd0, 3'd0, 3'd3},
        '{2'd3, 3'd2, 3'd5, 3'd4, 3'd3},
        '{2'd3, 3'd1, 3'd3, 3'd3, 3'd3}
    };

    // Record every flit that leaves, sampled 2 ns before the rising edge.
    initial begin
        for (int o = 0; o < N; o++) lc[o] = 0;
        forever begin
            @(negedge clk);
            #3;
            for (int o = 0; o < N; o++) begin
                if (rst_n && out_valid[o] && out_ready[o]) begin
                    lg[o][lc[o] % 64] = out_flit[o*FW +: FW];
                    lc[o] = lc[o] + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mk(input logic [1:0] kind, input logic [7:0] tag,
                                          input logic [7:0] idx, input logic [2:0] rf);
        return {kind, 40'h0, tag, idx, 5'h0, rf};
    endfunction

    // Called at a negedge; returns at the negedge after the accepting edge.
    task automatic send_flit(input int p, input logic [FW-1:0] f);
        in_flit[p*FW +: FW] = f;
        in_valid[p] = 1'b1;
        #3;
        while (!in_ready[p]) begin
            @(negedge clk);
            #3;
        end
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    task automatic send_pkt(input int p, input logic [2:0] rf, input logic [7:0] tag);
        send_flit(p, mk(2'b00, tag, 8'd0, rf));
        send_flit(p, mk(2'b01, tag, 8'd1, rf));
        send_flit(p, mk(2'b10, tag, 8'd2, rf));
    endtask

    // Write a depth while idle; R6: it takes effect at the next edge.
    task automatic set_mode(input logic [1:0] m);
        mode_wr_en = 1'b1;
        mode_wr_data = m;
        @(negedge clk);
        mode_wr_en = 1'b0;
        #3;
        chk(mode_o == m, "R6 idle write", FW'(mode_o), FW'(m));
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base, lat;
        logic [FW-1:0] got, f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        // Reset state (R2, R9)
        chk(mode_o == 2'd2, "R2 reset depth", FW'(mode_o), FW'(2));
        chk(in_ready == '1, "R9 ready after reset", FW'(in_ready), FW'(5'h1f));
        chk(out_valid == '0, "R9 no output after reset", FW'(out_valid), FW'(0));
        @(negedge clk);

        // R2: a write of zero is ignored
        mode_wr_en = 1'b1; mode_wr_data = 2'd0;
        @(negedge clk);
        mode_wr_en = 1'b0;
        @(negedge clk); #3;
        chk(mode_o == 2'd2, "R2 zero write ignored", FW'(mode_o), FW'(2));
        @(negedge clk);

        // Latency and routing table (R1, R3, R4, R5)
        for (int v = 0; v < 9; v++) begin
            if (mode_o != VT[v].mode) set_mode(VT[v].mode);
            f = mk(2'b11, 8'(v + 16), 8'd0, VT[v].rfield);
            send_flit(int'(VT[v].src), f);
            lat = 0;
            got = '0;
            for (int k = 1; k <= 6 && lat == 0; k++) begin
                #3;
                if (out_valid[VT[v].dport]) begin
                    lat = k;
                    got = out_flit[int'(VT[v].dport)*FW +: FW];
                end
                @(negedge clk);
            end
            chk(lat == int'(VT[v].lat),
                (VT[v].mode == 2'd1) ? "R3 latency" : (VT[v].mode == 2'd2) ? "R4 latency" : "R5 latency",
                FW'(lat), FW'(VT[v].lat));
            chk(got == f, "R1 route and payload", got, f);
            repeat (2) @(negedge clk);
        end

        // R6: writes held while a flit sits in an output latch; last write wins
        set_mode(2'd2);
        out_ready[1] = 1'b0;
        send_flit(0, mk(2'b11, 8'h55, 8'd0, 3'd1));
        mode_wr_en = 1'b1; mode_wr_data = 2'd3;
        @(negedge clk);
        mode_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        #3;
        chk(mode_o == 2'd2, "R6 held while busy", FW'(mode_o), FW'(2));
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_data = 2'd1;
        @(negedge clk);
        mode_wr_en = 1'b0;
        base = lc[1];
        out_ready[1] = 1'b1;
        repeat (4) @(negedge clk);
        #3;
        chk(mode_o == 2'd1, "R6 applied when idle, last write", FW'(mode_o), FW'(1));
        chk(lc[1] - base == 1, "R9 stalled flit delivered", FW'(lc[1] - base), FW'(1));
        @(negedge clk);

        // R7: two packets race for the South port
        set_mode(2'd2);
        base = lc[3];
        fork
            send_pkt(0, 3'd3, 8'hA0);
            send_pkt(2, 3'd3, 8'hB0);
        join
        repeat (10) @(negedge clk);
        chk(lc[3] - base == 6, "R7 flit count", FW'(lc[3] - base), FW'(6));
        for (int k = 0; k < 6; k++) begin
            got = lg[3][(base + k) % 64];
            chk(got[65:64] == ((k % 3 == 0) ? 2'b00 : (k % 3 == 1) ? 2'b01 : 2'b10),
                "R7 kind order", FW'(got[65:64]), FW'(k % 3));
            chk(got[23:16] == lg[3][(base + (k / 3) * 3) % 64][23:16], "R7 no interleave",
                FW'(got[23:16]), FW'(lg[3][(base + (k / 3) * 3) % 64][23:16]));
        end
        chk(lg[3][base % 64][23:16] != lg[3][(base + 3) % 64][23:16], "R7 both packets",
            FW'(lg[3][base % 64][23:16]), FW'(lg[3][(base + 3) % 64][23:16]));

        // R8: two backlogged inputs alternate on the Local port
        base = lc[4];
        fork
            begin
                send_flit(1, mk(2'b11, 8'h11, 8'd0, 3'd4));
                send_flit(1, mk(2'b11, 8'h11, 8'd1, 3'd4));
            end
            begin
                send_flit(3, mk(2'b11, 8'h33, 8'd0, 3'd4));
                send_flit(3, mk(2'b11, 8'h33, 8'd1, 3'd4));
            end
        join
        repeat (8) @(negedge clk);
        chk(lc[4] - base == 4, "R8 flit count", FW'(lc[4] - base), FW'(4));
        for (int k = 0; k < 3; k++) begin
            chk(lg[4][(base + k) % 64][23:16] != lg[4][(base + k + 1) % 64][23:16], "R8 alternation",
                FW'(lg[4][(base + k) % 64][23:16]), FW'(lg[4][(base + k + 1) % 64][23:16]));
        end

        // R9: fill the Local input in depth 1 with North stalled
        set_mode(2'd1);
        out_ready[0] = 1'b0;
        base = lc[0];
        lat = 0;
        for (int k = 0; k < 6; k++) begin
            in_flit[4*FW +: FW] = mk(2'b11, 8'h44, 8'(k), 3'd0);
            in_valid[4] = 1'b1;
            #3;
            if (in_ready[4]) begin
                lat++;
                @(negedge clk);
            end else begin
                in_valid[4] = 1'b0;
                break;
            end
        end
        in_valid[4] = 1'b0;
        chk(lat == 4, "R9 accepted until full", FW'(lat), FW'(4));
        @(negedge clk); #3;
        chk(in_ready[4] == 1'b0, "R9 ready low when full", FW'(in_ready[4]), FW'(0));
        @(negedge clk);
        out_ready[0] = 1'b1;
        repeat (8) @(negedge clk);
        chk(lc[0] - base == 4, "R9 nothing dropped", FW'(lc[0] - base), FW'(4));
        for (int k = 0; k < 4; k++) begin
            chk(lg[0][(base + k) % 64] == mk(2'b11, 8'h44, 8'(k), 3'd0), "R9 order kept",
                lg[0][(base + k) % 64], mk(2'b11, 8'h44, 8'(k), 3'd0));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule